// File: doc/BRIEF.md
# Cascadable stereo sample serializer

This block turns one stereo pair of converter results into a serial frame of 64 bits. The frame has two 32-bit halves, left first and then right. Each result sits at the top of its half, most significant bit first, and zeros fill the bits below the selected word width. A frame-sync edge copies the latest pair into the output shift register. From then on the register moves one bit toward the output per bit clock.

Instances can be chained, with the output of one feeding the serial input of the next. The register refills from the serial input at its tail, so each device sends its own 64 bits and then, with no gap, whatever its upstream neighbour is sending. A receiver at the end of a chain of N devices gets 2N words of 32 bits per sample period, nearest device first. The serial input of the device farthest from the receiver is tied low.

Results arrive on a parallel port qualified by a valid strobe. There is no ready signal and no back-pressure: a beat is accepted on every rising bit-clock edge where valid is high, and the newest beat replaces the previous one.

Top module: `cascade_serializer`

## Requirements
- R1: A frame is 64 bits: the left subframe (32 bits) first, then the right subframe (32 bits), each sent most significant bit first.
- R2: Width code on `smp_wid_i` selects the width: 2'b00 is 16 bits, 2'b01 is 20, and 2'b10 and 2'b11 are both 24. The result is taken from the top bits of the 24-bit input and placed at the top of its subframe. Every other subframe bit is zero.
- R3: A rising edge of `fsync_i`, seen at a rising bit-clock edge, loads the frame at the following falling edge. The left MSB is then on `sdout_o` for the whole next bit period.
- R4: Without a load, each falling edge shifts the frame one place toward `sdout_o`. The serial input, sampled at the rising edge, enters at the tail, so upstream bit k appears as output bit 64+k.
- R5: In a chain, the receiver sees near-left, near-right, far-left, far-right, and so on. After the last device's frame it sees zeros from the tied-low input.
- R6: While `casc_en_i` is low, `sdin_i` is ignored and zeros follow the device's own 64 bits.
- R7: A valid beat only updates the holding register. A beat that arrives mid-frame leaves the frame being shifted unchanged, and the next frame sync sends the new values.
- R8: A frame-sync edge during a shift reloads at once. The next bit out is the MSB of the new frame.
- R9: Holding `fsync_i` high loads only once. The frame keeps shifting until the next rising edge of `fsync_i`.
- R10: A synchronous active-low reset clears the holding and shift registers. `sdout_o` is then 0, and a frame loaded with no beat since reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock. Inputs are sampled on the rising edge; the output changes on the falling edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| smp_valid_i | input | 1 | Qualifies a sample beat |
| smp_left_i | input | SMP_W (24) | Left result, MSB aligned |
| smp_right_i | input | SMP_W (24) | Right result, MSB aligned |
| smp_wid_i | input | 2 | Word-width code |
| fsync_i | input | 1 | Frame sync; a rising edge starts a frame |
| casc_en_i | input | 1 | When high, upstream data is passed through |
| sdin_i | input | 1 | Serial data from the upstream device |
| sdout_o | output | 1 | Serial data toward the receiver |

## Verification
Suppose `fsync_i` rises before rising edge R0. The load happens at the falling edge after R0, and bit 0 of the frame is read 1 ns after R1, bit k 1 ns after R(k+1). The bench therefore drives every input 1 ns after a falling edge and reads `sdout_o` 1 ns after each rising edge, where the output has been stable for half a period. A valid beat registers at the next rising edge and has no visible effect until the next load. To test that, the bench sends mid-frame beats and reset pulses from a parallel thread, so the bit capture runs on without a gap. A two-device chain checks bit 64 onward against the upstream frame.

// File: rtl/cser_pkg.sv
package cser_pkg;

  typedef enum logic [1:0] {
    WID_16    = 2'd0,
    WID_20    = 2'd1,
    WID_24    = 2'd2,
    WID_24ALT = 2'd3
  } wid_e;

  // number of result bits kept at the top of each subframe
  function automatic logic [7:0] wid_bits(wid_e w);
    case (w)
      WID_16:  return 8'd16;
      WID_20:  return 8'd20;
      default: return 8'd24;
    endcase
  endfunction

endpackage

// File: rtl/cser_hold.sv
module cser_hold
  import cser_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic [1:0]       wid_i,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output wid_e             wid_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      wid_o   <= WID_24;
    end else if (valid_i) begin
      left_o  <= left_i;
      right_o <= right_i;
      wid_o   <= wid_e'(wid_i);
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(left_o) && $stable(right_o) && $stable(wid_o)));

endmodule

// File: rtl/cser_pack.sv
module cser_pack
  import cser_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int SUB_W = 32
) (
  input  logic [SMP_W-1:0]   left_i,
  input  logic [SMP_W-1:0]   right_i,
  input  wid_e               wid_i,
  output logic [2*SUB_W-1:0] frame_o
);

  localparam int PAD_W = SUB_W - SMP_W;

  logic [SMP_W-1:0] smp [2];
  logic [7:0]       keep_n;

  assign smp[0] = left_i;
  assign smp[1] = right_i;
  assign keep_n = wid_bits(wid_i);

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [SUB_W-1:0] raw;
    logic [SUB_W-1:0] sub;

    if (PAD_W > 0) begin : g_pad
      assign raw = {smp[ch], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign raw = smp[ch][SMP_W-1 -: SUB_W];
    end

    // keep a bit only if it lies within the top keep_n positions
    for (genvar b = 0; b < SUB_W; b++) begin : g_bit
      assign sub[b] = raw[b] & (8'(SUB_W - b) <= keep_n);
    end

    // channel 0 (left) occupies the upper half, sent first
    assign frame_o[(2-ch)*SUB_W-1 -: SUB_W] = sub;
  end

  // R2
  always_comb begin
    if (wid_i == WID_16) begin
      pad16_chk: assert (frame_o[15:0] == '0 && frame_o[SUB_W+15:SUB_W] == '0);
    end
  end

endmodule

// File: rtl/cser_shift.sv
module cser_shift #(
  parameter int FRM_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic             casc_en_i,
  input  logic             sdin_i,
  input  logic [FRM_W-1:0] frame_i,
  output logic             sdout_o
);

  logic             fs_d;
  logic             load_q;
  logic             sdin_q;
  logic [FRM_W-1:0] sreg;

  // rising edge: sample frame sync and upstream data
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fs_d   <= 1'b0;
      load_q <= 1'b0;
      sdin_q <= 1'b0;
    end else begin
      fs_d   <= fsync_i;
      load_q <= fsync_i & ~fs_d;
      sdin_q <= casc_en_i & sdin_i;
    end
  end

  // falling edge: load or shift the output register
  always_ff @(negedge clk_i) begin
    if (!rst_ni) begin
      sreg <= '0;
    end else if (load_q) begin
      sreg <= frame_i;
    end else begin
      sreg <= {sreg[FRM_W-2:0], sdin_q};
    end
  end

  assign sdout_o = sreg[FRM_W-1];

  // R3
  load_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    load_q |=> (sreg == $past(frame_i)));

  // R4
  shift_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !load_q |=> (sreg[FRM_W-1:1] == $past(sreg[FRM_W-2:0])));

  // R6
  casc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !casc_en_i |=> !sdin_q);

  // R9
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_i && fs_d) |=> !load_q);

endmodule

// File: rtl/cascade_serializer.sv
module cascade_serializer
  import cser_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int SUB_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  input  logic [1:0]       smp_wid_i,
  input  logic             fsync_i,
  input  logic             casc_en_i,
  input  logic             sdin_i,
  output logic             sdout_o
);

  localparam int FRM_W = 2 * SUB_W;

  logic [SMP_W-1:0] hold_l;
  logic [SMP_W-1:0] hold_r;
  wid_e             hold_w;
  logic [FRM_W-1:0] frame;

  cser_hold #(.SMP_W(SMP_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .left_i  (smp_left_i),
    .right_i (smp_right_i),
    .wid_i   (smp_wid_i),
    .left_o  (hold_l),
    .right_o (hold_r),
    .wid_o   (hold_w)
  );

  cser_pack #(.SMP_W(SMP_W), .SUB_W(SUB_W)) u_pack (
    .left_i  (hold_l),
    .right_i (hold_r),
    .wid_i   (hold_w),
    .frame_o (frame)
  );

  cser_shift #(.FRM_W(FRM_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fsync_i   (fsync_i),
    .casc_en_i (casc_en_i),
    .sdin_i    (sdin_i),
    .frame_i   (frame),
    .sdout_o   (sdout_o)
  );

endmodule

// File: tb/cascade_serializer_bench.sv
module cascade_serializer_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        casc_en = 1'b1;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic [23:0] a_l = '0, a_r = '0, b_l = '0, b_r = '0;
  logic [1:0]  a_w = 2'd2, b_w = 2'd2;
  logic        a_sdout, b_sdout;

  int checks = 0;
  int fails  = 0;

  // device nearest the receiver
  cascade_serializer u_cascade_serializer (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(a_valid), .smp_left_i(a_l),
    .smp_right_i(a_r), .smp_wid_i(a_w), .fsync_i(fsync), .casc_en_i(casc_en),
    .sdin_i(b_sdout), .sdout_o(a_sdout));

  // farthest device, serial input tied low
  cascade_serializer u_up (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(b_valid), .smp_left_i(b_l),
    .smp_right_i(b_r), .smp_wid_i(b_w), .fsync_i(fsync), .casc_en_i(1'b1),
    .sdin_i(1'b0), .sdout_o(b_sdout));

  function automatic logic [31:0] sub(input logic [23:0] s, input logic [1:0] w);
    int n;
    n = (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : 24;
    return {s, 8'h00} & ~(32'hFFFF_FFFF >> n);
  endfunction

  function automatic logic [63:0] frm(input logic [23:0] l, input logic [23:0] r,
                                      input logic [1:0] w);
    return {sub(l, w), sub(r, w)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_a(input logic [23:0] l, input logic [23:0] r, input logic [1:0] w);
    @(negedge clk); #1;
    a_l = l; a_r = r; a_w = w; a_valid = 1'b1;
    @(negedge clk); #1;
    a_valid = 1'b0;
  endtask

  task automatic set_b(input logic [23:0] l, input logic [23:0] r, input logic [1:0] w);
    @(negedge clk); #1;
    b_l = l; b_r = r; b_w = w; b_valid = 1'b1;
    @(negedge clk); #1;
    b_valid = 1'b0;
  endtask

  task automatic pulse_fs();
    @(negedge clk); #1;
    fsync = 1'b1;
    @(negedge clk); #1;
    fsync = 1'b0;
  endtask

  // capture n bits MSB first into the low bits of v
  task automatic grab(input int n, output logic [127:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      v = {v[126:0], a_sdout};
    end
  endtask

  task automatic t_reset();
    logic [127:0] v;
    grab(8, v);
    check("R10 idle output", v[63:0], 64'h0);
    pulse_fs();
    grab(128, v);
    check("R10 frame after reset", v[63:0], 64'h0);
  endtask

  task automatic t_widths();
    logic [127:0] v;
    for (int w = 0; w < 4; w++) begin
      set_a(24'hABCDEF, 24'h13579B, 2'(w));
      pulse_fs();
      grab(64, v);
      check($sformatf("R1/R2/R3 width code %0d", w), v[63:0],
            frm(24'hABCDEF, 24'h13579B, 2'(w)));
    end
  endtask

  task automatic t_chain();
    logic [127:0] v;
    logic [127:0] t;
    casc_en = 1'b1;
    set_a(24'h111111, 24'h222222, 2'd2);
    set_b(24'hF0F0F1, 24'h876543, 2'd1);
    pulse_fs();
    grab(128, v);
    grab(32, t);
    check("R5 near device words", v[127:64], frm(24'h111111, 24'h222222, 2'd2));
    check("R4 R5 far device words", v[63:0], frm(24'hF0F0F1, 24'h876543, 2'd1));
    check("R5 zeros after chain", t[63:0], 64'h0);
  endtask

  task automatic t_casc_off();
    logic [127:0] v;
    @(negedge clk); #1;
    casc_en = 1'b0;
    pulse_fs();
    grab(128, v);
    check("R6 own frame", v[127:64], frm(24'h111111, 24'h222222, 2'd2));
    check("R6 upstream ignored", v[63:0], 64'h0);
    @(negedge clk); #1;
    casc_en = 1'b1;
  endtask

  task automatic t_mid_update();
    logic [127:0] v;
    set_a(24'hC0FFEE, 24'h0BEEF0, 2'd2);
    pulse_fs();
    fork
      grab(64, v);
      begin
        repeat (10) @(negedge clk);
        #1; a_l = 24'h5A5A5A; a_r = 24'hA5A5A5; a_w = 2'd0; a_valid = 1'b1;
        @(negedge clk); #1; a_valid = 1'b0;
      end
    join
    check("R7 frame unchanged by mid beat", v[63:0], frm(24'hC0FFEE, 24'h0BEEF0, 2'd2));
    pulse_fs();
    grab(64, v);
    check("R7 new beat in next frame", v[63:0], frm(24'h5A5A5A, 24'hA5A5A5, 2'd0));
  endtask

  task automatic t_reload();
    logic [127:0] v;
    pulse_fs();
    grab(20, v);
    set_a(24'h987654, 24'h0F1E2D, 2'd1);
    pulse_fs();
    grab(64, v);
    check("R8 reload mid shift", v[63:0], frm(24'h987654, 24'h0F1E2D, 2'd1));
  endtask

  task automatic t_hold_high();
    logic [127:0] v;
    set_a(24'h7E57AB, 24'hD00D11, 2'd2);
    @(negedge clk); #1;
    fsync = 1'b1;
    @(negedge clk);
    fork
      grab(64, v);
      begin
        repeat (6) @(negedge clk);
        #1; fsync = 1'b0;
      end
    join
    check("R9 single load while high", v[63:0], frm(24'h7E57AB, 24'hD00D11, 2'd2));
  endtask

  task automatic t_mid_reset();
    logic [127:0] v;
    pulse_fs();
    grab(10, v);
    @(negedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    rst_n = 1'b1;
    grab(4, v);
    check("R10 output cleared by reset", v[63:0], 64'h0);
    pulse_fs();
    grab(64, v);
    check("R10 holding cleared by reset", v[63:0], 64'h0);
  endtask

  initial begin
    #(100000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_widths();
    t_chain();
    t_casc_off();
    t_mid_update();
    t_reload();
    t_hold_high();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule